// File: doc/BRIEF.md
# Two-Stage Rotating Load-Balanced Cell Switch

This block is an N-port cell switch that needs no scheduler and no request/grant exchange. Cells cross two fixed, rotating connection stages with buffering between them. A free-running slot counter steps once per clock. In each slot the first stage joins every external input to one intermediate port, chosen by rotation. This spreads arriving cells over all intermediate ports whatever their destination. Each intermediate port holds one FIFO per external output. The second stage, which also rotates, joins each intermediate port to one output. The port sends the head of the matching FIFO when that FIFO holds a cell; otherwise the slot goes unused.

Each cell carries a destination index and a sequence number. The switch adds the index of the input that injected it. Cells of one input/output flow may take different intermediate ports with different backlogs, so they can arrive out of order. Every output holds a small history per source and raises a flag with any cell whose sequence number is below the last one delivered from the same source.

Top module: `lbs_switch`

## Requirements
- R1: After reset `slot` reads 0. It then advances by one, modulo N, on every clock edge.
- R2: In a slot where `slot` = t, input i is joined to intermediate port (i + t) mod N. `in_ready[i]` is high exactly when that port's FIFO for the destination on `in_dst[i]` holds fewer than QDEPTH cells. A cell is taken when valid and ready are both high at the clock edge, and an input can inject at most one cell per slot.
- R3: In a slot where `slot` = t, intermediate port j is joined to output (j + t) mod N. It sends the head of its FIFO for that output only if the FIFO is non-empty. The cell appears on `out_valid`/`out_src`/`out_seq` during the next slot.
- R4: Each FIFO is first-in first-out with no bypass. A cell written at one edge can leave at a later edge at the earliest, so a cell accepted in slot t shows at its output after d + 1 edges, where d = (dst − j − t) mod N and d = 0 is taken as N. A full FIFO accepts nothing, even when it sends a cell at the same edge.
- R5: Every accepted cell is delivered exactly once, on the output equal to its destination, with its source index and sequence number unchanged.
- R6: `out_misorder[k]` is high only together with `out_valid[k]`. It is high exactly when `out_seq` is below the sequence number of the previous cell that output k delivered from the same source since reset. Every delivery becomes the new previous value for its source.
- R7: During and right after reset every `out_valid` and `out_misorder` is low, every FIFO is empty so every `in_ready` is high, and the order history is cleared.
- R8: When every input sends to one output without pause, that output delivers a cell in every slot from the third slot onward, once each intermediate port holds a cell for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cell slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N | Per input: a cell is offered |
| in_dst | input | N*IW | Per input: destination output index |
| in_seq | input | N*SEQ_W | Per input: sequence number of the offered cell |
| in_ready | output | N | Per input: the targeted intermediate FIFO has space |
| out_valid | output | N | Per output: a cell is delivered this slot |
| out_src | output | N*IW | Per output: source input of the delivered cell |
| out_seq | output | N*SEQ_W | Per output: sequence number of the delivered cell |
| out_misorder | output | N | Per output: delivered cell is older than the last one from its source |
| slot | output | IW | Current rotation slot |

## Verification
The bench sends single cells at chosen slots and checks the exact edge on which each appears. A stage that rotates the wrong way, or a FIFO that lets a cell through on the edge it was written, would deliver early, late or to the wrong output. One flow is set up so that the cell sent later overtakes the one sent earlier. A checker that compares in the wrong direction, or keeps one history for every source, would miss that event or flag the wrong cell. Saturating one output fills the FIFOs. This shows whether ready drops on full, whether a full FIFO wrongly takes a cell on an edge where it also pops (which would lose or duplicate cells), and whether the output idles although a cell is waiting. Uniform and skewed random traffic then checks that every cell is delivered exactly once and that the flag agrees with an independent history.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  // Rotation arithmetic shared by both stages.
  function automatic int unsigned ring_add(int unsigned a, int unsigned b, int unsigned n);
    return (a + b) % n;
  endfunction

  function automatic int unsigned ring_sub(int unsigned a, int unsigned b, int unsigned n);
    return (a + n - (b % n)) % n;
  endfunction
endpackage

// File: rtl/lbs_cell_fifo.sv
module lbs_cell_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem [DEPTH];
  logic [PW-1:0]   wp, rp;
  logic [CNTW-1:0] cnt;

  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= step_ptr(wp);
      if (pop)  rp <= step_ptr(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CNTW'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty); // R4
endmodule

// File: rtl/lbs_mid_port.sv
module lbs_mid_port #(
  parameter int N     = 4,
  parameter int DEPTH = 4,
  parameter int IW    = 2,
  parameter int SEQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [IW-1:0]    push_dst,
  input  logic [IW-1:0]    push_src,
  input  logic [SEQ_W-1:0] push_seq,
  input  logic [IW-1:0]    sel,
  output logic [N-1:0]     full_vec,
  output logic             head_valid,
  output logic [IW-1:0]    head_src,
  output logic [SEQ_W-1:0] head_seq
);
  localparam int CW = IW + SEQ_W;

  logic [N-1:0]  empty_v, push_v, pop_v;
  logic [CW-1:0] dout_v [N];

  for (genvar k = 0; k < N; k++) begin : g_voq
    assign push_v[k] = push && (push_dst == IW'(k));
    assign pop_v[k]  = (sel == IW'(k)) && !empty_v[k];
    lbs_cell_fifo #(.DEPTH(DEPTH), .W(CW)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push_v[k]),
      .din   ({push_src, push_seq}),
      .pop   (pop_v[k]),
      .dout  (dout_v[k]),
      .empty (empty_v[k]),
      .full  (full_vec[k])
    );
  end

  assign head_valid           = !empty_v[sel];
  assign {head_src, head_seq} = dout_v[sel];
endmodule

// File: rtl/lbs_order_mon.sv
module lbs_order_mon #(
  parameter int N     = 4,
  parameter int IW    = 2,
  parameter int SEQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [IW-1:0]    src,
  input  logic [SEQ_W-1:0] seq,
  output logic             flag
);
  logic [SEQ_W-1:0] last_seq [N];
  logic [N-1:0]     seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= '0;
      for (int s = 0; s < N; s++) last_seq[s] <= '0;
    end else if (valid) begin
      seen[src]     <= 1'b1;
      last_seq[src] <= seq;
    end
  end

  assign flag = valid && seen[src] && (seq < last_seq[src]);
endmodule

// File: rtl/lbs_switch.sv
module lbs_switch #(
  parameter  int N      = 4,
  parameter  int QDEPTH = 4,
  parameter  int SEQ_W  = 8,
  localparam int IW     = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       in_valid,
  input  logic [N*IW-1:0]    in_dst,
  input  logic [N*SEQ_W-1:0] in_seq,
  output logic [N-1:0]       in_ready,
  output logic [N-1:0]       out_valid,
  output logic [N*IW-1:0]    out_src,
  output logic [N*SEQ_W-1:0] out_seq,
  output logic [N-1:0]       out_misorder,
  output logic [IW-1:0]      slot
);
  logic [IW-1:0] slot_q;
  logic          live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
      live   <= 1'b0;
    end else begin
      slot_q <= IW'(lbs_pkg::ring_add(int'(slot_q), 1, N));
      live   <= 1'b1;
    end
  end
  assign slot = slot_q;

  // Per-slot rotation indices.
  logic [IW-1:0] feed_src [N];  // input feeding intermediate j
  logic [IW-1:0] mid_out  [N];  // output served by intermediate j
  logic [IW-1:0] out_feed [N];  // intermediate feeding output k
  logic [IW-1:0] in_tgt   [N];  // intermediate targeted by input i

  always_comb begin
    for (int x = 0; x < N; x++) begin
      feed_src[x] = IW'(lbs_pkg::ring_sub(x, int'(slot_q), N));
      mid_out[x]  = IW'(lbs_pkg::ring_add(x, int'(slot_q), N));
      out_feed[x] = IW'(lbs_pkg::ring_sub(x, int'(slot_q), N));
      in_tgt[x]   = IW'(lbs_pkg::ring_add(x, int'(slot_q), N));
    end
  end

  logic [N-1:0]     full_m [N];
  logic [N-1:0]     push_w, head_v;
  logic [IW-1:0]    push_dst_w [N];
  logic [SEQ_W-1:0] push_seq_w [N];
  logic [IW-1:0]    head_src [N];
  logic [SEQ_W-1:0] head_seq [N];

  // First stage and intermediate buffering.
  for (genvar j = 0; j < N; j++) begin : g_mid
    assign push_dst_w[j] = in_dst[int'(feed_src[j])*IW +: IW];
    assign push_seq_w[j] = in_seq[int'(feed_src[j])*SEQ_W +: SEQ_W];
    assign push_w[j]     = in_valid[feed_src[j]] && !full_m[j][push_dst_w[j]];

    lbs_mid_port #(.N(N), .DEPTH(QDEPTH), .IW(IW), .SEQ_W(SEQ_W)) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (push_w[j]),
      .push_dst   (push_dst_w[j]),
      .push_src   (feed_src[j]),
      .push_seq   (push_seq_w[j]),
      .sel        (mid_out[j]),
      .full_vec   (full_m[j]),
      .head_valid (head_v[j]),
      .head_src   (head_src[j]),
      .head_seq   (head_seq[j])
    );
  end

  for (genvar i = 0; i < N; i++) begin : g_ready
    assign in_ready[i] = !full_m[in_tgt[i]][in_dst[i*IW +: IW]];
  end

  // Second stage, registered at the output.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= '0;
      out_src   <= '0;
      out_seq   <= '0;
    end else begin
      for (int k = 0; k < N; k++) begin
        out_valid[k]              <= head_v[out_feed[k]];
        out_src[k*IW +: IW]       <= head_src[out_feed[k]];
        out_seq[k*SEQ_W +: SEQ_W] <= head_seq[out_feed[k]];
      end
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_mon
    lbs_order_mon #(.N(N), .IW(IW), .SEQ_W(SEQ_W)) u_mon (
      .clk   (clk),
      .rst_n (rst_n),
      .valid (out_valid[k]),
      .src   (out_src[k*IW +: IW]),
      .seq   (out_seq[k*SEQ_W +: SEQ_W]),
      .flag  (out_misorder[k])
    );
  end

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> int'(slot_q) == lbs_pkg::ring_add(int'($past(slot_q)), 1, N)); // R1
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !$past(live)) |-> (out_valid == '0)); // R7
  AST_FLAG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (out_misorder & ~out_valid) == '0); // R6
endmodule

// File: tb/lbs_switch_test.sv
`timescale 1ns/1ps
module lbs_switch_test;
  localparam int N = 4;
  localparam int QDEPTH = 4;
  localparam int SEQ_W = 8;
  localparam int IW = 2;
  localparam int SMAX = 1 << SEQ_W;

  // {src, dst, drive slot, edges until arrival}
  localparam logic [15:0] VEC [6] = '{16'h0102, 16'h2205, 16'h1323,
                                      16'h3014, 16'h3333, 16'h1032};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] in_valid = '0;
  logic [N*IW-1:0] in_dst = '0;
  logic [N*SEQ_W-1:0] in_seq = '0;
  logic [N-1:0] in_ready, out_valid, out_misorder;
  logic [N*IW-1:0] out_src;
  logic [N*SEQ_W-1:0] out_seq;
  logic [IW-1:0] slot;

  always #2 clk = ~clk;

  lbs_switch #(.N(N), .QDEPTH(QDEPTH), .SEQ_W(SEQ_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst(in_dst), .in_seq(in_seq),
    .in_ready(in_ready), .out_valid(out_valid), .out_src(out_src), .out_seq(out_seq),
    .out_misorder(out_misorder), .slot(slot));

  int n_chk = 0, n_bad = 0, reorders = 0, stalls = 0;
  int nsent [N][N];
  bit got [N][N][SMAX];
  bit seen [N][N];
  int last [N][N];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int s = 0; s < N; s++)
      for (int d = 0; d < N; d++) begin
        nsent[s][d] = 0; seen[s][d] = 0; last[s][d] = 0;
        for (int q = 0; q < SMAX; q++) got[s][d][q] = 0;
      end
  endtask

  // At a negedge: score outputs, drive inputs, record acceptance, move to next negedge.
  task automatic tick(input logic [N-1:0] v, input logic [N*IW-1:0] d);
    for (int k = 0; k < N; k++) begin
      if (out_valid[k]) begin
        int s, q;
        bit em;
        s = int'(out_src[k*IW +: IW]);
        q = int'(out_seq[k*SEQ_W +: SEQ_W]);
        check(q < nsent[s][k] && !got[s][k][q], "R5 delivery once", q, nsent[s][k]);
        got[s][k][q] = 1;
        em = seen[s][k] && (q < last[s][k]);
        if (em) reorders++;
        check(out_misorder[k] == em, "R6 flag", int'(out_misorder[k]), int'(em));
        seen[s][k] = 1; last[s][k] = q;
      end else if (out_misorder[k]) begin
        check(1'b0, "R6 flag without cell", 1, 0);
      end
    end
    for (int i = 0; i < N; i++) begin
      int dd;
      dd = int'(d[i*IW +: IW]);
      in_valid[i] = v[i] && (nsent[i][dd] < SMAX - 1);
      in_dst[i*IW +: IW] = IW'(dd);
      in_seq[i*SEQ_W +: SEQ_W] = SEQ_W'(nsent[i][dd]);
    end
    #1;
    for (int i = 0; i < N; i++) begin
      int dd;
      dd = int'(in_dst[i*IW +: IW]);
      if (in_valid[i] && in_ready[i]) nsent[i][dd]++;
      else if (in_valid[i]) stalls++;
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = '0; in_dst = '0; in_seq = '0;
    repeat (3) @(negedge clk);
    clear_model();
    rst_n = 1'b1;
  endtask

  task automatic final_count(input string tag);
    for (int s = 0; s < N; s++)
      for (int d = 0; d < N; d++) begin
        int c = 0;
        for (int q = 0; q < nsent[s][d]; q++) if (got[s][d][q]) c++;
        check(c == nsent[s][d], tag, c, nsent[s][d]);
      end
  endtask

  initial begin
    #(190000 * 4);
    check(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R7: reset state
    check(out_valid == '0 && out_misorder == '0, "R7 outputs idle", int'(out_valid), 0);
    check(in_ready == '1, "R7 all ready", int'(in_ready), 15);
    // R1: slot sequence
    for (int c = 0; c < 6; c++) begin
      check(int'(slot) == c % N, "R1 slot", int'(slot), c % N);
      tick('0, '0);
    end

    // R3/R4: table of single cells with exact arrival edge
    do_reset();
    for (int e = 0; e < 6; e++) begin
      int s, d, t, w, acc;
      s = int'(VEC[e][15:12]); d = int'(VEC[e][11:8]);
      t = int'(VEC[e][7:4]);   w = int'(VEC[e][3:0]);
      while (int'(slot) != t) tick('0, '0);
      acc = nsent[s][d];
      tick(N'(1) << s, (N*IW)'(d) << (s * IW));
      check(nsent[s][d] == acc + 1, "R2 accepted when empty", nsent[s][d], acc + 1);
      for (int c = 1; c <= w; c++) begin
        if (c < w) check(out_valid == '0, "R4 no early arrival", int'(out_valid), 0);
        else begin
          check(out_valid == (N'(1) << d), "R3 arrival port", int'(out_valid), 1 << d);
          check(int'(out_src[d*IW +: IW]) == s && out_seq[d*SEQ_W +: SEQ_W] == '0,
                "R5 cell fields", int'(out_src[d*IW +: IW]), s);
          check(out_misorder == '0, "R6 first cell not flagged", int'(out_misorder), 0);
        end
        tick('0, '0);
      end
    end

    // R6: later cell overtakes earlier one on flow input0 -> output1
    do_reset();
    while (int'(slot) != 1) tick('0, '0);
    tick(4'b0001, 8'h01);
    tick(4'b0001, 8'h01);
    tick('0, '0);
    check(out_valid[1] && out_seq[SEQ_W +: SEQ_W] == 8'd1 && !out_misorder[1],
          "R6 overtaking cell unflagged", int'(out_seq[SEQ_W +: SEQ_W]), 1);
    tick('0, '0);
    check(out_valid[1] && out_seq[SEQ_W +: SEQ_W] == 8'd0 && out_misorder[1],
          "R6 late cell flagged", int'(out_misorder[1]), 1);
    tick('0, '0);

    // R2/R8: saturate output 1 from all inputs
    do_reset();
    begin
      bit gap = 0, leak = 0;
      stalls = 0;
      for (int c = 0; c < 30; c++) begin
        if (c >= 3 && !out_valid[1]) gap = 1;
        if ((out_valid & 4'b1101) != '0) leak = 1;
        tick('1, 8'h55);
      end
      check(!gap, "R8 output busy every slot", int'(gap), 0);
      check(!leak, "R3 no cell to other outputs", int'(leak), 0);
      check(stalls > 0, "R2 ready drops on full", stalls, 1);
      for (int c = 0; c < 100; c++) tick('0, '0);
      final_count("R5 saturation delivered");
    end

    // Random traffic: uniform then skewed towards output 0
    do_reset();
    for (int c = 0; c < 1500; c++) begin
      logic [N-1:0] v;
      logic [N*IW-1:0] d;
      for (int i = 0; i < N; i++) begin
        v[i] = ($urandom % 10) < 7;
        d[i*IW +: IW] = IW'($urandom % N);
      end
      tick(v, d);
    end
    for (int c = 0; c < 1500; c++) begin
      logic [N-1:0] v;
      logic [N*IW-1:0] d;
      for (int i = 0; i < N; i++) begin
        v[i] = ($urandom % 2) == 0;
        d[i*IW +: IW] = (($urandom % 4) != 0) ? '0 : IW'($urandom % N);
      end
      tick(v, d);
    end
    for (int c = 0; c < 120; c++) tick('0, '0);
    final_count("R5 random delivered");
    $display("reordering events observed: %0d", reorders);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule